// File: doc/BRIEF.md
# SCL Bit Clock Divider

This block derives the bit timing for an I2C master from the system clock. Two stages in series set the SCL half period. A prescaler first divides the system clock by 32, 16, 8 or 4, chosen by a two-bit code. An 8-bit programmable divider then counts DIV+3 prescaled pulses for each half period. At every half-period boundary the block emits a one-cycle tick and toggles a free-running SCL reference. The full SCL period is therefore prescale × 2 × (DIV+3) system clocks.

The byte engine drives an enable level and a clock-stretch hold input. When enable is low, both counters clear and the reference rests high. When hold is asserted while the reference is high, the divider freezes, so the high phase lasts as long as a target holds the clock. The divider value is captured only at half-period boundaries. Software can therefore reprogram it at any time without producing a truncated or stretched phase.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset, half_tick_o is 0, scl_ref_o is 1 and toggle_en_o is 0 while en_i is 0.
- R2: The prescale code selects the system-clock divisor: code 00 → 32, 01 → 16, 10 → 8, 11 → 4.
- R3: With the block running and not held, successive half_tick_o pulses are exactly P×(DIV+3) system clocks apart, where P is the selected divisor and DIV is the 8-bit divider value (0..255).
- R4: scl_ref_o changes level in the same cycle that half_tick_o is high, and only then while running, giving a full period of 2×P×(DIV+3) clocks.
- R5: With en_i low, no half_tick_o is produced, scl_ref_o is 1 from the next cycle on, and both counters clear. After en_i rises, the first tick therefore arrives exactly P×(DIV+3) clocks later.
- R6: A change of div_i during a half period leaves that half period at its old length. The new value applies from the following half period.
- R7: While stretch_i is high and scl_ref_o is high, the divider holds and no tick occurs. While scl_ref_o is low, stretch_i has no effect on the half-period length.
- R8: toggle_en_o is high exactly when en_i is high and the divider is not held by stretch_i.
- R9: With code 00 and DIV = 49, the SCL period is 3328 system clocks, which is about 60 kHz from a 200 MHz clock.
- R10: half_tick_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Divider enable from the mode register |
| psel_i | input | 2 | Prescale code |
| div_i | input | 8 | Divider value DIV |
| stretch_i | input | 1 | Clock-stretch hold from the byte engine |
| half_tick_o | output | 1 | One-cycle pulse at each SCL half-period boundary |
| toggle_en_o | output | 1 | High while the divider is free to advance |
| scl_ref_o | output | 1 | Free-running SCL reference level |

## Verification
A wrong prescale count or an off-by-one in the divider limit shows up as a wrong interval between ticks. That error is visible on the first half period after enable, because the counters start from zero. A divider value captured at the wrong moment shows only on the half period in which div_i changes, so that interval and the one after it are measured separately. A hold that leaks into the low phase, or fails to freeze the high phase, shows as a tick appearing, or going missing, inside a window of a few hundred clocks around the stretch.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    PS_DIV32 = 2'b00,
    PS_DIV16 = 2'b01,
    PS_DIV8  = 2'b10,
    PS_DIV4  = 2'b11
  } psel_e;

  localparam int PRE_MAX = 32;

  // terminal count of the prescaler for a given code
  function automatic int pre_last(input logic [1:0] code);
    case (psel_e'(code))
      PS_DIV32: pre_last = 31;
      PS_DIV16: pre_last = 15;
      PS_DIV8:  pre_last = 7;
      default:  pre_last = 3;
    endcase
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_div_pkg::*;
#(
  parameter int PRE_W = $clog2(PRE_MAX)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] psel_i,
  output logic       pre_tick_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] last;

  assign last       = PRE_W'(pre_last(psel_i));
  // >= so a code change mid-count never overruns the counter
  assign pre_tick_o = run_i && (pcnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pcnt_q <= '0;
    else if (!run_i)     pcnt_q <= '0;
    else if (pre_tick_o) pcnt_q <= '0;
    else                 pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_halfper_cnt.sv
module scl_halfper_cnt #(
  parameter int DIV_W  = 8,
  parameter int OFFSET = 3,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             adv_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             boundary_o
);
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;

  assign lim_m1     = CNT_W'(div_q) + CNT_W'(OFFSET - 1);
  assign boundary_o = run_i && adv_i && (cnt_q == lim_m1);

  // divider value is sampled only at a boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (!run_i || boundary_o) begin
      cnt_q <= '0;
      div_q <= div_i;
    end else if (adv_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_phase_reg.sv
module scl_phase_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic boundary_i,
  output logic half_tick_o,
  output logic scl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_tick_o <= 1'b0;
      scl_o       <= 1'b1;
    end else if (!run_i) begin
      half_tick_o <= 1'b0;
      scl_o       <= 1'b1;
    end else begin
      half_tick_o <= boundary_i;
      if (boundary_i) scl_o <= ~scl_o;
    end
  end
endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
  parameter int DIV_W  = 8,
  parameter int OFFSET = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       psel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             stretch_i,
  output logic             half_tick_o,
  output logic             toggle_en_o,
  output logic             scl_ref_o
);
  logic pre_tick;
  logic hold;
  logic adv;
  logic boundary;

  // stretch only freezes the high phase
  assign hold        = stretch_i && scl_ref_o;
  assign adv         = pre_tick && !hold;
  assign toggle_en_o = en_i && !hold;

  scl_prescaler u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_i),
    .psel_i     (psel_i),
    .pre_tick_o (pre_tick)
  );

  scl_halfper_cnt #(.DIV_W(DIV_W), .OFFSET(OFFSET)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (en_i),
    .adv_i      (adv),
    .div_i      (div_i),
    .boundary_o (boundary)
  );

  scl_phase_reg u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (en_i),
    .boundary_i  (boundary),
    .half_tick_o (half_tick_o),
    .scl_o       (scl_ref_o)
  );
endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       psel_i,
  input logic [DIV_W-1:0] div_i,
  input logic             stretch_i,
  input logic             half_tick_o,
  input logic             toggle_en_o,
  input logic             scl_ref_o
);
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick_o |=> !half_tick_o);

  a_r4_toggle_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick_o |-> (scl_ref_o != $past(scl_ref_o)));

  a_r5_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_ref_o && !half_tick_o));

  a_r7_stretch_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stretch_i && scl_ref_o) |=> !half_tick_o);

  a_r8_gate_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_en_o |-> en_i);
endmodule

bind scl_clk_gen scl_clk_gen_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/scl_clk_gen_test.sv
`timescale 1ns/1ps
module scl_clk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] psel = 2'b00;
  logic [7:0] div = 8'd0;
  logic       stretch = 1'b0;
  logic       half_tick, toggle_en, scl_ref;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  scl_clk_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .psel_i(psel), .div_i(div),
    .stretch_i(stretch), .half_tick_o(half_tick), .toggle_en_o(toggle_en),
    .scl_ref_o(scl_ref)
  );

  // psel, div, expected half period in clocks
  localparam int NV = 7;
  localparam int V_PS  [NV] = '{0, 1, 2, 3, 3,    0,    2};
  localparam int V_DIV [NV] = '{0, 1, 5, 0, 255,  49,   17};
  localparam int V_HALF[NV] = '{96, 64, 64, 12, 1032, 1664, 160};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts negedges until a tick is seen
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!half_tick && n < 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, n2, cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(half_tick == 1'b0, "R1 tick", half_tick, 0);
    chk(scl_ref == 1'b1, "R1 scl", scl_ref, 1);
    chk(toggle_en == 1'b0, "R1 toggle_en", toggle_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      en = 1'b0;
      psel = 2'(V_PS[i]);
      div  = 8'(V_DIV[i]);
      repeat (2) @(negedge clk);
      en = 1'b1;
      wait_tick(n);
      chk(n == V_HALF[i], "R2 R5 first half period", n, V_HALF[i]);
      chk(scl_ref == 1'b0, "R4 scl low after tick", scl_ref, 0);
      wait_tick(n2);
      chk(n2 == V_HALF[i], "R3 half period", n2, V_HALF[i]);
      chk(scl_ref == 1'b1, "R4 scl high after tick", scl_ref, 1);
      @(negedge clk);
      chk(half_tick == 1'b0, "R10 single pulse", half_tick, 0);
      if (V_DIV[i] == 49 && V_PS[i] == 0)
        chk(n + n2 == 3328, "R9 60kHz period", n + n2, 3328);
    end

    // R8 toggle enable while running
    chk(toggle_en == 1'b1, "R8 toggle_en running", toggle_en, 1);

    // R6 divider update at boundary
    en = 1'b0; psel = 2'b11; div = 8'd0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    wait_tick(n);
    repeat (3) @(negedge clk);
    div = 8'd5;
    wait_tick(n);
    chk(n == 9, "R6 old length kept", n, 9);
    wait_tick(n);
    chk(n == 32, "R6 new length", n, 32);

    // R7 stretch: no effect low, freeze high
    div = 8'd2;
    wait_tick(n);
    if (scl_ref) wait_tick(n);
    stretch = 1'b1;
    wait_tick(n);
    chk(n == 20, "R7 low phase unaffected", n, 20);
    chk(scl_ref == 1'b1, "R7 scl high", scl_ref, 1);
    chk(toggle_en == 1'b0, "R8 toggle_en held", toggle_en, 0);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (half_tick) cnt++;
    end
    chk(cnt == 0, "R7 no tick while held", cnt, 0);
    chk(scl_ref == 1'b1, "R7 scl stays high", scl_ref, 1);
    stretch = 1'b0;
    @(negedge clk);
    chk(toggle_en == 1'b1, "R8 toggle_en released", toggle_en, 1);
    wait_tick(n);
    chk(n >= 16 && n <= 19, "R7 resume after release", n, 19);

    // R5 disable mid-run
    repeat (5) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(scl_ref == 1'b1, "R5 scl high when disabled", scl_ref, 1);
    chk(toggle_en == 1'b0, "R8 toggle_en disabled", toggle_en, 0);
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (half_tick) cnt++;
    end
    chk(cnt == 0, "R5 no tick when disabled", cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule